// File: doc/BRIEF.md
# Local Bus Address Decoder

This block turns each transfer on a 32-bit processor local bus into at most one device select. The targets are the boot ROM (flash or PROM, picked by a board strap), DRAM, SRAM, a window onto an external bus, and the local I/O space. Only the transfer-type codes of the normal address space are decoded. Other codes, such as interrupt acknowledge, reach no local device and no register.

After reset the boot ROM answers in its fixed high window and is also aliased at address zero, so the processor can fetch its reset vectors. Software then programs the DRAM, SRAM and external windows through a small register block on the same bus. It turns the low alias off with one bit and turns DRAM on with another. A bus timer watches every transfer. When it is enabled and no acknowledge arrives within the programmed number of clocks, it raises a one-cycle bus error, so an access that nothing claims does not hang the bus.

Top module: `lbus_decoder`

## Requirements
- R1: A transfer with type code 3 asserts no select, no `regAck` and no register write. Codes 0, 1 and 2 are decoded.
- R2: After reset the ROM select (flash when `flashStrap`=1, otherwise PROM) is asserted for 0xFF800000–0xFF9FFFFF and for 0x00000000–0x003FFFFF, and DRAM is off.
- R3: Writing 1 to bit 20 of the register at 0xFFF42040 removes the low ROM alias. The high ROM window stays.
- R4: Bit 24 of 0xFFF42048 enables DRAM. The DRAM window comes from 0xFFF42044: bits 31:22 give the base, and bits 1:0 give the size (0=4 MB, 1=8 MB, 2 or 3=16 MB). The base is aligned down to the size.
- R5: While the low ROM alias is active, addresses in 0x00000000–0x003FFFFF select ROM even when DRAM is enabled there.
- R6: `romAddr` always carries the low 19 address bits, so the device contents repeat across the ROM window.
- R7: `flashStrap`=1 steers ROM accesses to `selFlash`. `flashStrap`=0 steers them to `selProm`.
- R8: The SRAM register at 0xFFF4204C has three fields: bits 31:17 base, bit 4 enable, and bits 2:0 size code giving 128 KB shifted left by the code (codes above 4 mean 2 MB). The base is aligned down to the size.
- R9: The external window register at 0xFFF42050 has three fields: bits 31:24 base, bits 23:16 mask, and bit 0 enable. An address hits when its bits 31:24 equal the base on every bit set in the mask.
- R10: 0xFFF00000–0xFFFEFFFF selects local I/O, except the register block 0xFFF42040–0xFFF4205F, which selects nothing and answers with a `regAck` pulse in the start cycle.
- R11: The selects are one-hot or all zero. Priority runs from register block, to I/O, to ROM, to DRAM, to SRAM, to external.
- R12: The timer register is at 0xFFF42054, with bit 0 enable (reset 0) and bits 31:16 limit (reset 256). When enabled, a transfer that has no `busAck` gets a one-cycle `busErr` in the limit-th cycle after its start cycle. An acknowledge or a new start restarts the timer.
- R13: Registers read back their defined fields on `rdData` when a normal transfer addresses them. Undefined bits and unused offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busValid | input | 1 | Transfer in progress |
| busStart | input | 1 | First cycle of a transfer |
| busWrite | input | 1 | Write transfer |
| busTt | input | 2 | Transfer-type code |
| busAddr | input | 32 | Byte address |
| busWdata | input | 32 | Write data |
| busAck | input | 1 | Acknowledge from the selected device |
| flashStrap | input | 1 | Board strap choosing flash over PROM |
| selProm | output | 1 | PROM select |
| selFlash | output | 1 | Flash select |
| selDram | output | 1 | DRAM select |
| selSram | output | 1 | SRAM select |
| selExt | output | 1 | External bus window select |
| selIo | output | 1 | Local I/O select |
| romAddr | output | 19 | Device address for ROM |
| rdData | output | 32 | Register read data |
| regAck | output | 1 | Register access acknowledge |
| busErr | output | 1 | Bus-timeout error pulse |

## Verification
Two pairs of functions can claim the same cycle. The first pair is the boot alias and an enabled DRAM window starting at zero. The bench enables DRAM while the alias is still on, and expects ROM below 4 MB and DRAM above it. The second pair is the timer and a new register write that lands on a running timeout. A write to the timer register while an unacknowledged transfer is pending must cancel the pending count, and the per-cycle model judges the exact cycle of every `busErr` against the start cycle it recorded.

// File: rtl/lbd_pkg.sv
package lbd_pkg;
  localparam logic [31:0] REG_BASE  = 32'hFFF42040;
  localparam logic [31:0] ROM_HI    = 32'hFF800000;
  localparam int ALIAS_BIT   = 20;
  localparam int DRAM_EN_BIT = 24;
  localparam int SRAM_EN_BIT = 4;
  localparam int NSEL = 6;
  localparam int SEL_PROM  = 0;
  localparam int SEL_FLASH = 1;
  localparam int SEL_DRAM  = 2;
  localparam int SEL_SRAM  = 3;
  localparam int SEL_EXT   = 4;
  localparam int SEL_IO    = 5;
  localparam logic [2:0] OFS_ROM  = 3'd0;
  localparam logic [2:0] OFS_DWIN = 3'd1;
  localparam logic [2:0] OFS_DCTL = 3'd2;
  localparam logic [2:0] OFS_SRAM = 3'd3;
  localparam logic [2:0] OFS_EXT  = 3'd4;
  localparam logic [2:0] OFS_TMO  = 3'd5;

  typedef struct packed {
    logic        aliasOff;
    logic        dramEn;
    logic [9:0]  dramBase;
    logic [1:0]  dramSize;
    logic        sramEn;
    logic [14:0] sramBase;
    logic [2:0]  sramSize;
    logic        extEn;
    logic [7:0]  extBase;
    logic [7:0]  extMask;
  } decCfg_t;
endpackage

// File: rtl/lbd_decode.sv
module lbd_decode
  import lbd_pkg::*;
(
  input  logic            busValid,
  input  logic [1:0]      busTt,
  input  logic [31:2]     addrHi,
  input  logic            flashStrap,
  input  decCfg_t         cfg,
  output logic            regHit,
  output logic [2:0]      regOfs,
  output logic [NSEL-1:0] sel
);
  logic normal, ioHit, romHit, dramHit, sramHit, extHit;
  logic [9:0]  dMask;
  logic [2:0]  sCode;
  logic [14:0] sMask;

  assign normal = busValid && (busTt != 2'd3);
  assign regHit = normal && (addrHi[31:5] == REG_BASE[31:5]);
  assign regOfs = addrHi[4:2];
  assign ioHit  = normal && (addrHi[31:20] == 12'hFFF) && (addrHi[19:16] != 4'hF);

  assign romHit = normal && ((addrHi[31:21] == ROM_HI[31:21]) ||
                             (!cfg.aliasOff && addrHi[31:22] == 10'd0));

  always_comb begin
    case (cfg.dramSize)
      2'd0:    dMask = 10'h3FF;
      2'd1:    dMask = 10'h3FE;
      default: dMask = 10'h3FC;
    endcase
  end
  assign dramHit = normal && cfg.dramEn &&
                   (((addrHi[31:22] ^ cfg.dramBase) & dMask) == 10'd0);

  assign sCode   = (cfg.sramSize > 3'd4) ? 3'd4 : cfg.sramSize;
  assign sMask   = 15'h7FFF << sCode;
  assign sramHit = normal && cfg.sramEn &&
                   (((addrHi[31:17] ^ cfg.sramBase) & sMask) == 15'd0);

  assign extHit  = normal && cfg.extEn &&
                   (((addrHi[31:24] ^ cfg.extBase) & cfg.extMask) == 8'd0);

  always_comb begin
    sel = '0;
    if (regHit)       sel = '0;
    else if (ioHit)   sel[SEL_IO] = 1'b1;
    else if (romHit)  sel[flashStrap ? SEL_FLASH : SEL_PROM] = 1'b1;
    else if (dramHit) sel[SEL_DRAM] = 1'b1;
    else if (sramHit) sel[SEL_SRAM] = 1'b1;
    else if (extHit)  sel[SEL_EXT] = 1'b1;
  end
endmodule

// File: rtl/lbd_ctrl.sv
module lbd_ctrl
  import lbd_pkg::*;
#(
  parameter int TMO_W   = 16,
  parameter int TMO_RST = 256
)(
  input  logic        clk,
  input  logic        rstN,
  input  logic        busStart,
  input  logic        busWrite,
  input  logic [31:0] busWdata,
  input  logic        busAck,
  input  logic        regHit,
  input  logic [2:0]  regOfs,
  output decCfg_t     cfg,
  output logic [31:0] rdData,
  output logic        regAck,
  output logic        busErr
);
  decCfg_t          cfgQ;
  logic             tmoEn, active, wrEn;
  logic [TMO_W-1:0] tmoLim, cnt;
  wire              unusedWd = ^{busWdata[15:5], busWdata[3]};

  assign wrEn   = busStart && busWrite && regHit;
  assign regAck = busStart && regHit;
  assign cfg    = cfgQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cfgQ   <= '0;
      tmoEn  <= 1'b0;
      tmoLim <= TMO_W'(TMO_RST);
    end else if (wrEn) begin
      case (regOfs)
        OFS_ROM:  cfgQ.aliasOff <= busWdata[ALIAS_BIT];
        OFS_DWIN: begin
          cfgQ.dramBase <= busWdata[31:22];
          cfgQ.dramSize <= busWdata[1:0];
        end
        OFS_DCTL: cfgQ.dramEn <= busWdata[DRAM_EN_BIT];
        OFS_SRAM: begin
          cfgQ.sramBase <= busWdata[31:17];
          cfgQ.sramEn   <= busWdata[SRAM_EN_BIT];
          cfgQ.sramSize <= busWdata[2:0];
        end
        OFS_EXT: begin
          cfgQ.extBase <= busWdata[31:24];
          cfgQ.extMask <= busWdata[23:16];
          cfgQ.extEn   <= busWdata[0];
        end
        OFS_TMO: begin
          tmoEn  <= busWdata[0];
          tmoLim <= busWdata[16 +: TMO_W];
        end
        default: ;
      endcase
    end
  end

  always_comb begin
    rdData = '0;
    if (regHit) begin
      case (regOfs)
        OFS_ROM:  rdData[ALIAS_BIT] = cfgQ.aliasOff;
        OFS_DWIN: begin
          rdData[31:22] = cfgQ.dramBase;
          rdData[1:0]   = cfgQ.dramSize;
        end
        OFS_DCTL: rdData[DRAM_EN_BIT] = cfgQ.dramEn;
        OFS_SRAM: begin
          rdData[31:17]       = cfgQ.sramBase;
          rdData[SRAM_EN_BIT] = cfgQ.sramEn;
          rdData[2:0]         = cfgQ.sramSize;
        end
        OFS_EXT: begin
          rdData[31:24] = cfgQ.extBase;
          rdData[23:16] = cfgQ.extMask;
          rdData[0]     = cfgQ.extEn;
        end
        OFS_TMO: begin
          rdData[16 +: TMO_W] = tmoLim;
          rdData[0]           = tmoEn;
        end
        default: ;
      endcase
    end
  end

  assign busErr = active && tmoEn && (cnt == tmoLim - TMO_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active <= 1'b0;
      cnt    <= '0;
    end else if (busStart) begin
      active <= !regHit;
      cnt    <= '0;
    end else if (active) begin
      if (busAck || busErr) active <= 1'b0;
      else                  cnt    <= cnt + TMO_W'(1);
    end
  end
endmodule

// File: rtl/lbus_decoder.sv
module lbus_decoder
  import lbd_pkg::*;
#(
  parameter int ROM_AW  = 19,
  parameter int TMO_W   = 16,
  parameter int TMO_RST = 256
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              busValid,
  input  logic              busStart,
  input  logic              busWrite,
  input  logic [1:0]        busTt,
  input  logic [31:0]       busAddr,
  input  logic [31:0]       busWdata,
  input  logic              busAck,
  input  logic              flashStrap,
  output logic              selProm,
  output logic              selFlash,
  output logic              selDram,
  output logic              selSram,
  output logic              selExt,
  output logic              selIo,
  output logic [ROM_AW-1:0] romAddr,
  output logic [31:0]       rdData,
  output logic              regAck,
  output logic              busErr
);
  decCfg_t         cfg;
  logic            regHit;
  logic [2:0]      regOfs;
  logic [NSEL-1:0] sel;

  lbd_decode u_dec (
    .busValid(busValid), .busTt(busTt), .addrHi(busAddr[31:2]),
    .flashStrap(flashStrap), .cfg(cfg),
    .regHit(regHit), .regOfs(regOfs), .sel(sel)
  );

  lbd_ctrl #(.TMO_W(TMO_W), .TMO_RST(TMO_RST)) u_ctl (
    .clk(clk), .rstN(rstN), .busStart(busStart), .busWrite(busWrite),
    .busWdata(busWdata), .busAck(busAck), .regHit(regHit), .regOfs(regOfs),
    .cfg(cfg), .rdData(rdData), .regAck(regAck), .busErr(busErr)
  );

  assign selProm  = sel[SEL_PROM];
  assign selFlash = sel[SEL_FLASH];
  assign selDram  = sel[SEL_DRAM];
  assign selSram  = sel[SEL_SRAM];
  assign selExt   = sel[SEL_EXT];
  assign selIo    = sel[SEL_IO];
  assign romAddr  = busAddr[ROM_AW-1:0];
endmodule

// File: rtl/lbd_chk.sv
module lbd_chk (
  input logic        clk,
  input logic        rstN,
  input logic        busValid,
  input logic [1:0]  busTt,
  input logic [10:0] addrTop,
  input logic [5:0]  sel,
  input logic        regAck,
  input logic        busErr,
  input logic        aliasOff
);
  // R11
  sel_onehot_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(sel));

  // R1
  iack_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busTt == 2'd3) |-> (sel == 6'd0 && !regAck));

  // R12
  err_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    busErr |=> !busErr);

  // R5
  alias_prio_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busTt != 2'd3 && !aliasOff && addrTop[10:1] == 10'd0)
      |-> (sel[0] || sel[1]));

  // R2
  rom_high_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busValid && busTt != 2'd3 && addrTop == 11'h7FC) |-> (sel[0] || sel[1]));
endmodule

bind lbus_decoder lbd_chk u_chk (
  .clk(clk), .rstN(rstN), .busValid(busValid), .busTt(busTt),
  .addrTop(busAddr[31:21]), .sel(sel), .regAck(regAck), .busErr(busErr),
  .aliasOff(cfg.aliasOff)
);

// File: tb/sim_lbus_decoder.sv
module sim_lbus_decoder;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic busValid = 0, busStart = 0, busWrite = 0, busAck = 0, flashStrap = 0;
  logic [1:0]  busTt = 0;
  logic [31:0] busAddr = 0, busWdata = 0;
  logic selProm, selFlash, selDram, selSram, selExt, selIo, regAck, busErr;
  logic [18:0] romAddr;
  logic [31:0] rdData;

  always #5 clk = ~clk;

  lbus_decoder u0 (
    .clk(clk), .rstN(rstN), .busValid(busValid), .busStart(busStart),
    .busWrite(busWrite), .busTt(busTt), .busAddr(busAddr), .busWdata(busWdata),
    .busAck(busAck), .flashStrap(flashStrap), .selProm(selProm),
    .selFlash(selFlash), .selDram(selDram), .selSram(selSram), .selExt(selExt),
    .selIo(selIo), .romAddr(romAddr), .rdData(rdData), .regAck(regAck),
    .busErr(busErr)
  );

  int total = 0, bad = 0;
  bit finished = 0;
  string curReq = "R2";

  // reference model state
  logic [31:0] mRom, mDwin, mDctl, mSram, mExt, mTmo;
  bit pending;
  longint cyc = 0, startCyc = 0;
  bit expErr = 0;

  function automatic bit inBlock(logic v, logic [1:0] t, logic [31:0] a);
    return v && t != 2'd3 && a >= 32'hFFF42040 && a < 32'hFFF42060;
  endfunction

  function automatic logic [5:0] expSel(logic v, logic [1:0] t, logic [31:0] a, logic strap);
    longint ua, sz, st;
    int code;
    ua = longint'(a);
    if (!v || t == 2'd3) return 6'd0;
    if (inBlock(v, t, a)) return 6'd0;
    if (ua >= 64'hFFF00000 && ua < 64'hFFFF0000) return 6'b100000;
    if ((ua >= 64'hFF800000 && ua <= 64'hFF9FFFFF) || (!mRom[20] && ua < 64'h400000))
      return strap ? 6'b000010 : 6'b000001;
    if (mDctl[24]) begin
      code = int'(mDwin[1:0]); if (code > 2) code = 2;
      sz = 64'h400000 << code;
      st = longint'(mDwin & 32'hFFC00000) & ~(sz - 1);
      if (ua >= st && ua < st + sz) return 6'b000100;
    end
    if (mSram[4]) begin
      code = int'(mSram[2:0]); if (code > 4) code = 4;
      sz = 64'h20000 << code;
      st = longint'(mSram & 32'hFFFE0000) & ~(sz - 1);
      if (ua >= st && ua < st + sz) return 6'b001000;
    end
    if (mExt[0] && ((a[31:24] & mExt[23:16]) == (mExt[31:24] & mExt[23:16])))
      return 6'b010000;
    return 6'd0;
  endfunction

  function automatic logic [31:0] expRd(logic v, logic [1:0] t, logic [31:0] a);
    if (!inBlock(v, t, a)) return 32'd0;
    case (a[4:2])
      3'd0: return mRom;
      3'd1: return mDwin;
      3'd2: return mDctl;
      3'd3: return mSram;
      3'd4: return mExt;
      3'd5: return mTmo;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc++;
    if (!rstN) begin
      mRom = 0; mDwin = 0; mDctl = 0; mSram = 0; mExt = 0;
      mTmo = 32'd256 << 16; pending = 0;
    end else if (busStart) begin
      if (busWrite && inBlock(busValid, busTt, busAddr)) begin
        case (busAddr[4:2])
          3'd0: mRom  = busWdata & 32'h00100000;
          3'd1: mDwin = busWdata & 32'hFFC00003;
          3'd2: mDctl = busWdata & 32'h01000000;
          3'd3: mSram = busWdata & 32'hFFFE0017;
          3'd4: mExt  = busWdata & 32'hFFFF0001;
          3'd5: mTmo  = busWdata & 32'hFFFF0001;
          default: ;
        endcase
      end
      pending  = !inBlock(busValid, busTt, busAddr);
      startCyc = cyc;
    end else if (pending && (busAck || expErr)) begin
      pending = 0;
    end
  end

  task automatic fail(string what, longint act, longint exp);
    bad++;
    $display("FAIL %s %s act=%h exp=%h", curReq, what, act, exp);
  endtask

  always @(negedge clk) begin
    logic [5:0] eSel, aSel;
    logic [31:0] eRd;
    bit eAck, eErr;
    if (!finished) begin
      eSel = expSel(busValid, busTt, busAddr, flashStrap);
      eRd  = expRd(busValid, busTt, busAddr);
      eAck = busStart && inBlock(busValid, busTt, busAddr);
      eErr = rstN && pending && mTmo[0] &&
             (cyc - startCyc + 1 == longint'(mTmo[31:16]));
      expErr = eErr;
      aSel = {selIo, selExt, selSram, selDram, selFlash, selProm};
      total += 4;
      if (aSel !== eSel) fail("sel", longint'(aSel), longint'(eSel));
      if (romAddr !== busAddr[18:0]) fail("romAddr", longint'(romAddr), longint'(busAddr[18:0]));
      if (rdData !== eRd) fail("rdData", longint'(rdData), longint'(eRd));
      if ({regAck, busErr} !== {eAck, eErr})
        fail("ack/err", longint'({regAck, busErr}), longint'({eAck, eErr}));
    end
  end

  task automatic go(input logic [31:0] a, input logic [1:0] t, input logic w,
                    input logic [31:0] d, input int len, input bit ack);
    @(posedge clk); #1;
    busValid = 1; busStart = 1; busAddr = a; busTt = t; busWrite = w;
    busWdata = d; busAck = 0;
    for (int i = 1; i < len; i++) begin
      @(posedge clk); #1;
      busStart = 0; busAck = (ack && i == len - 1);
    end
    @(posedge clk); #1;
    busValid = 0; busStart = 0; busAck = 0; busWrite = 0;
  endtask

  task automatic rd(input logic [31:0] a);  go(a, 2'd0, 1'b0, 32'd0, 2, 1'b1); endtask
  task automatic wr(input logic [31:0] a, input logic [31:0] d); go(a, 2'd1, 1'b1, d, 1, 1'b0); endtask

  task automatic summary();
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      bad++; total++;
      $display("FAIL watchdog act=hung exp=done");
      summary();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    // R2: reset map
    curReq = "R2";
    rd(32'h00000000); rd(32'h003FFFFC); rd(32'hFF800000); rd(32'hFF9FFFFC);
    rd(32'h00400000); rd(32'hFFA00000); rd(32'h00800000);
    // R7: strap steering
    curReq = "R7";
    flashStrap = 1; rd(32'h00001000); rd(32'hFF812344); flashStrap = 0; rd(32'hFF812344);
    // R6: ROM repeat
    curReq = "R6";
    rd(32'hFF8C1234); rd(32'h003C1234);
    // R1: interrupt acknowledge ignored, then observed through readback
    curReq = "R1";
    go(32'h00000000, 2'd3, 1'b0, 0, 2, 1'b1);
    go(32'hFFF42040, 2'd3, 1'b1, 32'h00100000, 1, 1'b0);
    go(32'hFFF42040, 2'd2, 1'b0, 0, 1, 1'b0);
    rd(32'h00000010);
    // R13: readback
    curReq = "R13";
    wr(32'hFFF42044, 32'hFFFFFFFE); rd(32'hFFF42044);
    wr(32'hFFF42044, 32'h00000002);
    wr(32'hFFF4204C, 32'h40000010); rd(32'hFFF4204C);
    wr(32'hFFF42050, 32'h80C00001); rd(32'hFFF42050);
    rd(32'hFFF42054); rd(32'hFFF42058); rd(32'hFFF4205C);
    // R5: alias wins over DRAM
    curReq = "R5";
    wr(32'hFFF42048, 32'hFFFFFFFF); rd(32'hFFF42048);
    rd(32'h00100000); rd(32'h00800000); rd(32'h00FFFFFC); rd(32'h01000000);
    // R3: alias removed
    curReq = "R3";
    wr(32'hFFF42040, 32'h00100000); rd(32'hFFF42040);
    rd(32'h00100000); rd(32'hFF800000);
    // R4: DRAM window and enable
    curReq = "R4";
    wr(32'hFFF42044, 32'h02000000);
    rd(32'h02000000); rd(32'h023FFFFC); rd(32'h02400000);
    wr(32'hFFF42044, 32'h02400001); rd(32'h02000000); rd(32'h027FFFFC);
    wr(32'hFFF42048, 32'h0); rd(32'h02000000);
    // R8: SRAM sizes
    curReq = "R8";
    rd(32'h4001FFFC); rd(32'h40020000);
    wr(32'hFFF4204C, 32'h40000012); rd(32'h4007FFFC); rd(32'h40080000);
    wr(32'hFFF4204C, 32'h40000017); rd(32'h401FFFFC); rd(32'h40200000);
    // R9: external window
    curReq = "R9";
    rd(32'h80000000); rd(32'hBFFFFFFC); rd(32'hC0000000); rd(32'h7FFFFFFC);
    // R10: I/O space and register hole
    curReq = "R10";
    rd(32'hFFF00000); rd(32'hFFFEFFFC); rd(32'hFFFF0000);
    go(32'hFFF4205C, 2'd0, 1'b0, 0, 1, 1'b0); rd(32'hFFF42060);
    // R11: SRAM overlapping external window
    curReq = "R11";
    wr(32'hFFF4204C, 32'h80000010); rd(32'h80000100); rd(32'h80020000);
    // R12: bus timeout
    curReq = "R12";
    wr(32'hFFF42054, 32'h00080001);
    go(32'h60000000, 2'd0, 1'b0, 0, 12, 1'b0);
    go(32'h60000000, 2'd0, 1'b0, 0, 5, 1'b1);
    go(32'h60000000, 2'd0, 1'b0, 0, 5, 1'b0);
    wr(32'hFFF42054, 32'h00080000);
    go(32'h60000000, 2'd0, 1'b0, 0, 12, 1'b0);
    wr(32'hFFF42054, 32'h01000001);
    go(32'h60000000, 2'd0, 1'b0, 0, 260, 1'b0);
    repeat (3) @(posedge clk);
    summary();
  end
endmodule